// File: doc/BRIEF.md
# Framed SPI Packet Transmitter

This block is the SPI master that moves one stored frame to a radio. Each frame goes out as a three-byte header followed by the payload. The first header byte is the sync marker 0xAA. The next two bytes carry the payload length. The payload bytes come from a byte-wide buffer, which the block reads through a synchronous read port. The receiver uses the marker and the length to find frame boundaries again after it loses alignment.

A client places the payload in the buffer and pulses a start request with the byte count. The block drives chip select, the serial clock and the data line. It walks the buffer addresses from zero upward and fetches each byte before it is needed, so the bytes of a frame go out back to back with no gap. Busy stays high for the whole frame, and a one-cycle done pulse marks the end. The serial clock rate is a build-time divider of the system clock.

Top module: `frame_spi_tx`

## Requirements
- R1: The first byte shifted out after chip select falls is the marker 0xAA.
- R2: The marker is followed by the 16-bit length taken from `len_i` when the start is accepted, high byte first and then low byte.
- R3: After the length come exactly `len_i` payload bytes, read from buffer addresses 0, 1, 2 and so on in that order. The read port has one cycle of latency: data is presented on `buf_data_i` in the cycle after a cycle in which `buf_rd_o` is high.
- R4: SPI mode 0, MSB first. `spi_sclk_o` idles low. `spi_mosi_o` changes only while the serial clock is low and is sampled on the rising edge.
- R5: Every high phase and every low phase of the serial clock within a frame lasts CLK_DIV+1 system cycles.
- R6: Chip select falls in the cycle after an accepted start, and the first rising edge of the serial clock comes CLK_DIV+1 cycles later. Chip select rises in the same cycle as the last falling edge of the serial clock, so only whole bytes are sent.
- R7: `busy_o` is high from the cycle after an accepted start until chip select rises.
- R8: A start request made while `busy_o` is high is ignored. It changes neither the frame in progress nor its length, and it starts no frame afterwards.
- R9: `done_o` is high for exactly one cycle, which is the cycle in which chip select rises and `busy_o` falls.
- R10: A length of zero sends only the marker and the two length bytes.
- R11: After reset, chip select is high, the serial clock is low, and `busy_o`, `done_o` and `buf_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to send one frame |
| len_i | input | 16 | Payload byte count, sampled when the start is accepted |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| buf_addr_o | output | ADDR_W | Payload buffer read address |
| buf_rd_o | output | 1 | Payload buffer read strobe |
| buf_data_i | input | 8 | Payload buffer read data, valid one cycle after the strobe |
| spi_sclk_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data out, MSB first |
| spi_cs_n_o | output | 1 | Chip select, active low |

## Verification
Chip select and busy respond in the cycle after the start is accepted. The first serial clock rise comes CLK_DIV+1 cycles later, and every later serial clock edge follows the one before it by the same interval. Done and the rise of chip select land together on the edge of the last falling serial clock. The bench counts system cycles from the fall of chip select and from each serial clock edge, and it samples on the falling system clock edge, after every register has settled. A scoreboard collects the bytes that the driver queued and compares them with the bytes that the monitor rebuilds from the rising serial clock edges, one at a time.

// File: rtl/frame_spi_tx_pkg.sv
package frame_spi_tx_pkg;
  localparam int FRM_LEN_W = 16;
  localparam int HDR_BYTES = 3;
  localparam logic [7:0] SYNC_BYTE = 8'hAA;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seq_st_t;
endpackage

// File: rtl/frame_spi_tx_clkgen.sv
module frame_spi_tx_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (CLK_DIV > 0) ? $clog2(CLK_DIV + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV);

  logic [CNT_W-1:0] hcnt_q, hcnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = run_i && (hcnt_q == CNT_LAST);

  always_comb begin
    hcnt_d = hcnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      hcnt_d = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      hcnt_d = '0;
      sclk_d = ~sclk_q;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
endmodule

// File: rtl/frame_spi_tx_shifter.sv
module frame_spi_tx_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       fall_i,
  output logic       mosi_o,
  output logic       last_bit_o
);
  logic [7:0] sh_q, sh_d;
  logic [2:0] bcnt_q, bcnt_d;
  logic       sh_en;

  assign sh_en = load_i || (fall_i && (bcnt_q != 3'd7));

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    if (load_i) begin
      sh_d   = load_byte_i;
      bcnt_d = '0;
    end else if (fall_i && (bcnt_q != 3'd7)) begin
      sh_d   = {sh_q[6:0], 1'b0};
      bcnt_d = bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign mosi_o     = sh_q[7];
  assign last_bit_o = (bcnt_q == 3'd7);
endmodule

// File: rtl/frame_spi_tx_seq.sv
module frame_spi_tx_seq
  import frame_spi_tx_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [FRM_LEN_W-1:0] len_i,
  input  logic                 fall_i,
  input  logic                 last_bit_i,
  output logic                 load_o,
  output logic [7:0]           load_byte_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    buf_addr_o,
  output logic                 buf_rd_o,
  input  logic [7:0]           buf_data_i
);
  localparam int IDX_W = FRM_LEN_W + 1;

  seq_st_t              st_q, st_d;
  logic [FRM_LEN_W-1:0] len_q;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0]    pa_q, pa_d;
  logic [ADDR_W-1:0]    addr_q;
  logic                 rd_q, rdv_q;
  logic [7:0]           pf_q;
  logic                 done_q;

  logic                 start_ok, byte_end, more, adv, fin, rd_req;
  logic [IDX_W-1:0]     nidx, total, load_idx;

  assign start_ok = start_i && (st_q == ST_IDLE);
  assign byte_end = (st_q == ST_SEND) && fall_i && last_bit_i;
  assign nidx     = idx_q + 1'b1;
  assign total    = {1'b0, len_q} + IDX_W'(HDR_BYTES);
  assign more     = nidx < total;
  assign adv      = byte_end && more;
  assign fin      = byte_end && !more;
  assign load_idx = start_ok ? '0 : nidx;
  assign load_o   = start_ok || adv;
  // prefetch the payload byte that follows the one being loaded
  assign rd_req   = load_o && (load_idx >= IDX_W'(2)) &&
                    ((load_idx - IDX_W'(2)) < {1'b0, len_q});

  always_comb begin
    if (start_ok)                  load_byte_o = SYNC_BYTE;
    else if (nidx == IDX_W'(1))    load_byte_o = len_q[15:8];
    else if (nidx == IDX_W'(2))    load_byte_o = len_q[7:0];
    else                           load_byte_o = pf_q;
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    pa_d  = pa_q;
    if (start_ok) begin
      st_d  = ST_SEND;
      idx_d = '0;
      pa_d  = '0;
    end else begin
      if (fin) st_d = ST_IDLE;
      if (adv) idx_d = nidx;
      if (rd_req) pa_d = pa_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pa_q   <= '0;
      rd_q   <= 1'b0;
      rdv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pa_q   <= pa_d;
      rd_q   <= rd_req;
      rdv_q  <= rd_q;
      done_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      addr_q <= '0;
      pf_q   <= '0;
    end else begin
      if (start_ok) len_q  <= len_i;
      if (rd_req)   addr_q <= pa_q;
      if (rdv_q)    pf_q   <= buf_data_i;
    end
  end

  assign busy_o     = (st_q == ST_SEND);
  assign done_o     = done_q;
  assign buf_addr_o = addr_q;
  assign buf_rd_o   = rd_q;
endmodule

// File: rtl/frame_spi_tx.sv
module frame_spi_tx
  import frame_spi_tx_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rd_o,
  input  logic [7:0]        buf_data_i,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  output logic              spi_cs_n_o
);
  logic       busy, rise, fall, load, last_bit;
  logic [7:0] load_byte;

  frame_spi_tx_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .fall_i      (fall),
    .last_bit_i  (last_bit),
    .load_o      (load),
    .load_byte_o (load_byte),
    .busy_o      (busy),
    .done_o      (done_o),
    .buf_addr_o  (buf_addr_o),
    .buf_rd_o    (buf_rd_o),
    .buf_data_i  (buf_data_i)
  );

  frame_spi_tx_clkgen #(.CLK_DIV(CLK_DIV)) i_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .sclk_o (spi_sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  frame_spi_tx_shifter i_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_byte_i (load_byte),
    .fall_i      (fall),
    .mosi_o      (spi_mosi_o),
    .last_bit_o  (last_bit)
  );

  logic unused_rise;
  assign unused_rise = rise;

  assign busy_o     = busy;
  assign spi_cs_n_o = ~busy;
endmodule

// File: rtl/frame_spi_tx_chk.sv
module frame_spi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic buf_rd_o,
  input logic spi_sclk_o,
  input logic spi_mosi_o,
  input logic spi_cs_n_o
);
  // R4: serial clock rests low whenever no frame is active
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !spi_sclk_o);

  // R4: data holds while the serial clock stays high
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: done coincides with the end of busy
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7: a frame begins only after a start request
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R3: buffer reads happen only inside a frame
  p_rd_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |-> !spi_cs_n_o);
endmodule

bind frame_spi_tx frame_spi_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .buf_rd_o   (buf_rd_o),
  .spi_sclk_o (spi_sclk_o),
  .spi_mosi_o (spi_mosi_o),
  .spi_cs_n_o (spi_cs_n_o)
);

// File: tb/test_frame_spi_tx.sv
module test_frame_spi_tx;
  localparam int CLK_DIV = 2;
  localparam int ADDR_W  = 14;
  localparam int HALF    = CLK_DIV + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [15:0]       len_i = '0;
  logic              busy_o, done_o, buf_rd_o;
  logic [ADDR_W-1:0] buf_addr_o;
  logic [7:0]        buf_data_i = '0;
  logic              spi_sclk_o, spi_mosi_o, spi_cs_n_o;

  frame_spi_tx #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) i_frame_spi_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .buf_addr_o(buf_addr_o),
    .buf_rd_o(buf_rd_o), .buf_data_i(buf_data_i), .spi_sclk_o(spi_sclk_o),
    .spi_mosi_o(spi_mosi_o), .spi_cs_n_o(spi_cs_n_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [7:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pay(input logic [ADDR_W-1:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd7) ^ s ^ {2'b0, a[13:8]};
  endfunction

  // buffer model: synchronous read, one cycle latency
  always @(posedge clk) if (buf_rd_o) buf_data_i <= pay(buf_addr_o, seed);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor state
  logic       prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
  int         bitn = 0, bytepos = 0, t_cs = 0, t_edge = 0;
  bit         first_rise = 1'b0, half_err = 1'b0, mosi_err = 1'b0;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n_o) begin
        t_cs = cyc; bitn = 0; bytepos = 0; first_rise = 1'b1;
        half_err = 1'b0; mosi_err = 1'b0;
      end
      if (!spi_cs_n_o && (spi_sclk_o != prev_sclk)) begin
        if (first_rise) begin
          check(cyc - t_cs == HALF, "R6 first rise delay", cyc - t_cs, HALF);
          first_rise = 1'b0;
        end else if (cyc - t_edge != HALF) half_err = 1'b1;
        t_edge = cyc;
      end
      if (spi_sclk_o && prev_sclk && spi_mosi_o != prev_mosi) mosi_err = 1'b1;
      if (spi_sclk_o && !prev_sclk) begin
        acc = {acc[6:0], spi_mosi_o};
        bitn++;
        if (bitn == 8) begin
          bitn = 0;
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", acc, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(acc == e, bytepos == 0 ? "R1 marker" :
                  (bytepos < 3 ? "R2 length" : "R3 payload"), acc, e);
          end
          bytepos++;
        end
      end
      if (!prev_cs && spi_cs_n_o) begin
        if (prev_sclk) begin
          // last falling edge coincides with the release of chip select
          if (cyc - t_edge != HALF) half_err = 1'b1;
        end
        check(prev_sclk && !spi_sclk_o && bitn == 0, "R6 release on last fall", bitn, 0);
        check(done_o && !busy_o, "R9 done with release", done_o, 1);
        check(!half_err, "R5 half period", half_err, 0);
        check(!mosi_err, "R4 mosi stable while sclk high", mosi_err, 0);
        check(exp_q.size() == 0, "R3 byte count", exp_q.size(), 0);
      end
      prev_sclk = spi_sclk_o; prev_cs = spi_cs_n_o; prev_mosi = spi_mosi_o;
    end
  end

  task automatic send_frame(input int len, input logic [7:0] s, input bit poke);
    while (busy_o) @(negedge clk);
    seed = s;
    exp_q.push_back(8'hAA);
    exp_q.push_back(len[15:8]);
    exp_q.push_back(len[7:0]);
    for (int i = 0; i < len; i++) exp_q.push_back(pay(ADDR_W'(i), s));
    len_i = 16'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !spi_cs_n_o, "R7 busy and R6 cs after start", busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      len_i = 16'd7; start_i = 1'b1;   // R8: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    // R9: done drops after one cycle
    @(negedge clk);
    check(!done_o, "R9 single cycle done", done_o, 0);
    if (poke) begin
      bit any;
      any = 1'b0;
      repeat (30) begin @(negedge clk); if (busy_o || !spi_cs_n_o) any = 1'b1; end
      check(!any, "R8 ignored start begins no frame", any, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n_o && !spi_sclk_o && !busy_o && !done_o && !buf_rd_o,
          "R11 reset state", {spi_cs_n_o, spi_sclk_o, busy_o, done_o, buf_rd_o}, 16);
    send_frame(0, 8'h11, 1'b0);    // R10
    send_frame(1, 8'h22, 1'b0);
    send_frame(5, 8'h3C, 1'b1);    // R8
    send_frame(40, 8'h5A, 1'b0);
    send_frame(300, 8'hC3, 1'b0);
    send_frame(2, 8'hFF, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule